// File: doc/BRIEF.md
# Recirculating Subranging Conversion Sequencer

This block is the control and digital datapath of a subranging converter that owns only one coarse quantizer. It reuses that quantizer and its DAC for several passes. After the first pass, an analog switch and a programmable-gain amplifier send the residue back to the same stage. The sequencer starts a conversion on the leading edge of a sample strobe and generates every later timing step itself. It drives the hold, feedback-switch and gain-select controls, and gives each pass a programmable settling interval.

At the end of each pass, the 3-bit code from the stage is stored in a per-pass buffer slot. Every slot therefore holds data from the same sample. When the last pass is done, a correction adder combines the slots into a 7-bit word. Adjacent passes overlap by one bit, so each later pass carries a weight four times smaller than the one before it. If the adder overflows, the result is forced to the all-ones code.

The finished word leaves on a valid/ready stream. The valid signal and the word are held stable until the consumer accepts them. The conversion ends on the cycle of acceptance, and a new sample is accepted only after that. A one-cycle end-of-conversion pulse marks the first cycle in which the word is valid. The analog loop lies outside the block.

Top module: `rsc_seq`

## Requirements
- R1: While reset is active and right after it, busy_o, hold_o, fb_sel_o, res_valid_o and eoc_o are all 0.
- R2: When the sequencer is idle, a rising edge of smp_strobe_i (low at one clock edge, high at the next) starts a conversion. busy_o and hold_o are 1 in the following cycle.
- R3: hold_o is 1 during sampling and during every pass. gain_sel_o gives the pass index: 0 for the first pass, 1 for the second, 2 for the third. fb_sel_o is 1 exactly in the passes whose index is not 0, and it is never 1 while hold_o is 0.
- R4: settle_cfg_i is captured when the conversion starts, as a value S. Each pass lasts S+1 cycles, and its code is captured in the last of them. res_valid_o rises 3*S+5 clock edges after the edge that detected the strobe.
- R5: The result is c0*16 + c1*4 + c2. Here c0, c1 and c2 are the pass_code_i values captured in passes 0, 1 and 2.
- R6: If that sum exceeds 127, res_data_o is 127 (all ones).
- R7: A strobe edge that arrives while busy_o is 1 has no effect on the result or its timing. A strobe held high through the end of a conversion does not start another one.
- R8: res_valid_o stays at 1 with res_data_o stable until res_ready_i is 1. The cycle after that handshake, busy_o and res_valid_o are 0. eoc_o is 1 only in the first cycle of res_valid_o.
- R9: Changing settle_cfg_i during a conversion does not change the timing of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| smp_strobe_i | input | 1 | Sample strobe; a rising edge starts a conversion |
| settle_cfg_i | input | 8 | Settle cycles per pass minus one |
| pass_code_i | input | 3 | Code from the shared quantizer stage |
| hold_o | output | 1 | Hold the analog sample |
| fb_sel_o | output | 1 | 0 = input path, 1 = residue feedback path |
| gain_sel_o | output | 2 | Amplifier gain select, equal to the pass index |
| busy_o | output | 1 | Conversion in progress or result pending |
| res_data_o | output | 7 | Corrected result word |
| res_valid_o | output | 1 | Result valid (stream valid) |
| res_ready_i | input | 1 | Consumer ready (stream ready) |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The bench targets these corner cases:

- **Saturation boundary.** Sums of exactly 127 and of 128 are tested. A carry handled wrongly would wrap 128 to 0, and a weight placed wrongly would give a different value.
- **Settle count of zero.** An off-by-one in the pass counter would show up as a shifted latency.
- **Strobe while busy.** Strobe edges are injected during a conversion, and settle_cfg_i is changed at the same time. A design that restarts, or that reads the setting live, would change the latency or the word.
- **Stalled result and held strobe.** Holding res_ready_i low checks that the word stays in place. Holding the strobe high across completion catches a design that detects the level instead of the edge, because it would start again at once.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_PASS,
    ST_CORRECT,
    ST_DONE
  } rsc_state_e;
endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int NPASS  = 3,
  parameter int CNT_W  = 8,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic              res_ready_i,
  output logic              lat_en_o,
  output logic [PIDX_W-1:0] lat_idx_o,
  output logic              hold_o,
  output logic              fb_sel_o,
  output logic [PIDX_W-1:0] gain_o,
  output logic              busy_o,
  output logic              cor_en_o,
  output logic              res_valid_o,
  output logic              eoc_o
);
  localparam logic [PIDX_W-1:0] LAST_IDX = PIDX_W'(NPASS - 1);

  rsc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  settle_q;
  logic [PIDX_W-1:0] pidx_q;
  logic              strobe_q;
  logic              eoc_q;
  logic              start;
  logic              settled;

  assign start   = (state_q == ST_IDLE) && strobe_i && !strobe_q;
  assign settled = (cnt_q == settle_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      settle_q <= '0;
      pidx_q   <= '0;
      strobe_q <= 1'b0;
      eoc_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      eoc_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_SAMPLE;
            settle_q <= settle_i;
          end
        end
        ST_SAMPLE: begin
          state_q <= ST_PASS;
          cnt_q   <= '0;
          pidx_q  <= '0;
        end
        ST_PASS: begin
          if (settled) begin
            cnt_q <= '0;
            if (pidx_q == LAST_IDX) state_q <= ST_CORRECT;
            else pidx_q <= pidx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CORRECT: begin
          state_q <= ST_DONE;
          eoc_q   <= 1'b1;
        end
        ST_DONE: begin
          if (res_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lat_en_o    = (state_q == ST_PASS) && settled;
    lat_idx_o   = pidx_q;
    hold_o      = (state_q == ST_SAMPLE) || (state_q == ST_PASS);
    fb_sel_o    = (state_q == ST_PASS) && (pidx_q != '0);
    gain_o      = (state_q == ST_PASS) ? pidx_q : '0;
    busy_o      = (state_q != ST_IDLE);
    cor_en_o    = (state_q == ST_CORRECT);
    res_valid_o = (state_q == ST_DONE);
    eoc_o       = eoc_q;
  end
endmodule

// File: rtl/rsc_codebuf.sv
module rsc_codebuf #(
  parameter int NPASS  = 3,
  parameter int CODE_W = 3,
  parameter int PIDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lat_en_i,
  input  logic [PIDX_W-1:0]       lat_idx_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic [NPASS*CODE_W-1:0] codes_o
);
  for (genvar k = 0; k < NPASS; k++) begin : g_slot
    logic [CODE_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (lat_en_i && (lat_idx_i == PIDX_W'(k))) slot_q <= code_i;
    end
    assign codes_o[k*CODE_W +: CODE_W] = slot_q;
  end
endmodule

// File: rtl/rsc_corrector.sv
module rsc_corrector #(
  parameter int NPASS  = 3,
  parameter int CODE_W = 3,
  parameter int OVL    = 1,
  parameter int RES_W  = 7
) (
  input  logic [NPASS*CODE_W-1:0] codes_i,
  output logic [RES_W-1:0]        word_o
);
  localparam int STEP  = CODE_W - OVL;
  localparam int SUM_W = RES_W + CODE_W;

  logic [SUM_W-1:0] sum;
  logic             carry;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NPASS; k++) begin
      sum = sum + (SUM_W'(codes_i[k*CODE_W +: CODE_W]) << (STEP * (NPASS - 1 - k)));
    end
  end

  assign carry  = |sum[SUM_W-1:RES_W];
  assign word_o = carry ? {RES_W{1'b1}} : sum[RES_W-1:0];
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq #(
  parameter int NPASS  = 3,
  parameter int CODE_W = 3,
  parameter int OVL    = 1,
  parameter int CNT_W  = 8,
  localparam int PIDX_W = $clog2(NPASS),
  localparam int RES_W  = CODE_W + (NPASS - 1) * (CODE_W - OVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_strobe_i,
  input  logic [CNT_W-1:0]  settle_cfg_i,
  input  logic [CODE_W-1:0] pass_code_i,
  output logic              hold_o,
  output logic              fb_sel_o,
  output logic [PIDX_W-1:0] gain_sel_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              eoc_o
);
  logic                    lat_en;
  logic [PIDX_W-1:0]       lat_idx;
  logic                    cor_en;
  logic [NPASS*CODE_W-1:0] codes;
  logic [RES_W-1:0]        word;
  logic [RES_W-1:0]        res_q;

  rsc_ctrl #(.NPASS(NPASS), .CNT_W(CNT_W), .PIDX_W(PIDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (smp_strobe_i),
    .settle_i    (settle_cfg_i),
    .res_ready_i (res_ready_i),
    .lat_en_o    (lat_en),
    .lat_idx_o   (lat_idx),
    .hold_o      (hold_o),
    .fb_sel_o    (fb_sel_o),
    .gain_o      (gain_sel_o),
    .busy_o      (busy_o),
    .cor_en_o    (cor_en),
    .res_valid_o (res_valid_o),
    .eoc_o       (eoc_o)
  );

  rsc_codebuf #(.NPASS(NPASS), .CODE_W(CODE_W), .PIDX_W(PIDX_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_en_i  (lat_en),
    .lat_idx_i (lat_idx),
    .code_i    (pass_code_i),
    .codes_o   (codes)
  );

  rsc_corrector #(.NPASS(NPASS), .CODE_W(CODE_W), .OVL(OVL), .RES_W(RES_W)) u_cor (
    .codes_i (codes),
    .word_o  (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (cor_en) res_q <= word;
  end

  assign res_data_o = res_q;
endmodule

// File: rtl/rsc_seq_chk.sv
module rsc_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 3,
  parameter int PIDX_W = 2,
  parameter int RES_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_strobe_i,
  input logic [CNT_W-1:0]  settle_cfg_i,
  input logic [CODE_W-1:0] pass_code_i,
  input logic              hold_o,
  input logic              fb_sel_o,
  input logic [PIDX_W-1:0] gain_sel_o,
  input logic              busy_o,
  input logic [RES_W-1:0]  res_data_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic              eoc_o
);
  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy_o && smp_strobe_i && !$past(smp_strobe_i)) |=> (busy_o && hold_o));

  // R3
  fb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && gain_sel_o != '0) |-> fb_sel_o);

  // R3
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_sel_o |-> hold_o);

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !res_valid_o) |=> busy_o);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i) |=> (!busy_o && !res_valid_o));

  // R8
  eoc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> res_valid_o);

  // R8
  eoc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);
endmodule

bind rsc_seq rsc_seq_chk #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .PIDX_W(PIDX_W), .RES_W(RES_W)
) u_chk (.*);

// File: tb/rsc_seq_tb.sv
`timescale 1ns/1ps
module rsc_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [7:0] settle = '0;
  logic [2:0] code;
  logic       hold, fb_sel, busy, res_valid, res_ready = 1'b0, eoc;
  logic [1:0] gain_sel;
  logic [6:0] res_data;
  logic [2:0] tb_code [3];

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // analog-loop model: the stage returns the code chosen for the current pass
  assign code = (gain_sel < 2'd3) ? tb_code[gain_sel] : 3'd0;

  rsc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .smp_strobe_i(strobe), .settle_cfg_i(settle),
    .pass_code_i(code), .hold_o(hold), .fb_sel_o(fb_sel), .gain_sel_o(gain_sel),
    .busy_o(busy), .res_data_o(res_data), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .eoc_o(eoc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(input int a, input int b, input int c);
    int s;
    s = a * 16 + b * 4 + c;
    return (s > 127) ? 127 : s;
  endfunction

  task automatic conv(input int a, input int b, input int c, input int s,
                      input bit intrude, input int stall, input bit keep);
    int k;
    int ew;
    bit sel_bad;
    tb_code[0] = 3'(a); tb_code[1] = 3'(b); tb_code[2] = 3'(c);
    settle = 8'(s);
    ew = exp_word(a, b, c);
    sel_bad = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        chk(busy && hold, "R2 start", int'(busy), 1);
        if (!keep) strobe = 1'b0;
      end
      if (intrude && !keep) begin
        if (k == 3) strobe = 1'b1;
        if (k == 4) begin strobe = 1'b0; settle = 8'(s + 3); end
      end
      if (hold && ((gain_sel != 2'd0) != fb_sel)) sel_bad = 1'b1;
      if (!hold && fb_sel) sel_bad = 1'b1;
    end while (!res_valid && k < 2000);
    chk(k < 2000, "R4 watchdog", k, 3 * s + 6);
    chk(k == 3 * s + 6, intrude ? "R7/R9 latency" : "R4 latency", k, 3 * s + 6);
    chk(int'(res_data) == ew, (ew == 127) ? "R6 saturate" : "R5 word", int'(res_data), ew);
    chk(eoc == 1'b1, "R8 eoc pulse", int'(eoc), 1);
    chk(!sel_bad, "R3 switch/gain", int'(sel_bad), 0);
    for (int j = 0; j < stall; j++) begin
      @(negedge clk);
      chk(res_valid && int'(res_data) == ew, "R8 stall hold", int'(res_data), ew);
      chk(!eoc, "R8 eoc once", int'(eoc), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && !busy, "R8 release", int'(busy), 0);
    if (keep) begin
      repeat (4) @(negedge clk);
      chk(!busy, "R7 held strobe", int'(busy), 0);
      strobe = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    tb_code[0] = '0; tb_code[1] = '0; tb_code[2] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !res_valid && !eoc && !fb_sel, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !hold && !res_valid && !eoc && !fb_sel, "R1 after reset", int'(busy), 0);

    conv(0, 0, 0, 0, 1'b0, 0, 1'b0);
    conv(7, 3, 3, 0, 1'b0, 0, 1'b0);   // R5 edge: 127 without carry
    conv(7, 3, 4, 1, 1'b0, 0, 1'b0);   // R6: 128 saturates
    conv(7, 4, 0, 2, 1'b0, 2, 1'b0);   // R6
    conv(7, 7, 7, 0, 1'b0, 0, 1'b0);   // R6 max
    conv(2, 5, 1, 3, 1'b1, 1, 1'b0);   // R7 and R9 intrusion
    conv(4, 1, 6, 1, 1'b0, 0, 1'b1);   // R7 held strobe
    conv(1, 7, 7, 4, 1'b0, 3, 1'b0);   // R5 overlap

    for (int i = 0; i < 30; i++) begin
      conv(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
           int'($urandom % 5), 1'($urandom % 2), int'($urandom % 3), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule